// File: doc/BRIEF.md
# Power-Down Exit Output Sequencer

This block decides, for each group of clock outputs of a clock generator, whether the output pins float, sit at a static high level, or carry the running clock. While the power-down request is high, every group floats. When the request drops, all groups are parked high in the very next reference cycle. They stay parked until the PLL reports lock. The groups are then released to running one per reference cycle, in a fixed order starting with the lowest index.

A timeout counter bounds the wait for lock. If lock has not been seen within the configured number of parked cycles, an error flag is raised and the outputs stay parked. Raising power-down again at any point sends everything back to high impedance in the next cycle, clears the error and restarts the sequence. The drive-mode codes feed the output pad drivers. The real analog timing is modelled only as counts of reference cycles.

Top module: `pd_exit_seq`

## Requirements
- R1: While rst_ni is low, every group's mode code is 2'b00 (high impedance) and err_o is 0. Group g occupies mode_o bits [2g+1:2g]. The codes are 00 high impedance, 01 parked high and 10 running.
- R2: When pwr_dn_i is sampled high, every group reads 2'b00 and err_o reads 0 after that clock edge, whatever the phase before it (parked, ramping, running or fault).
- R3: When pwr_dn_i is sampled low while all groups read 2'b00, every group reads 2'b01 after that edge.
- R4: When lock_i is sampled high in a parked cycle, group 0 reads 2'b10 after that edge. Group g reads 2'b10 g edges later. Groups not yet released keep 2'b01.
- R5: lock_i has no effect while power-down is held or during the float-to-park step. The first cycle after release is always fully parked, even with lock_i already high.
- R6: If lock_i stays low for TIMEOUT_CYC parked edges, err_o reads 1 after the TIMEOUT_CYC-th such edge. All groups keep 2'b01 and a later lock_i does not release them.
- R7: lock_i sampled high on the last parked edge before expiry (edge TIMEOUT_CYC) still starts the release, and err_o stays 0.
- R8: Once release has started, lock_i going low has no effect: the remaining groups are still released one per edge and then stay running.
- R9: The code 2'b11 never appears, and a group never runs while a lower-indexed group does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_dn_i | input | 1 | Power-down request, active high |
| lock_i | input | 1 | PLL lock indication |
| mode_o | output | 2*N_GRP | Per-group drive-mode codes |
| err_o | output | 1 | Lock timeout flag |

## Verification
The hardest points to reach are the two edges of the timeout window. Lock seen on exactly the last parked edge must still release the groups, and lock one edge later must not. The bench reaches both by sweeping the lock arrival delay over every parked cycle count from zero to past the timeout, so both edges of the window come up in the same sweep. A second sweep raises power-down after each possible number of released groups. This covers a restart from every intermediate ramp state.

// File: rtl/pd_exit_seq_pkg.sv
package pd_exit_seq_pkg;
  typedef enum logic [1:0] {
    DRV_HIZ  = 2'b00,
    DRV_HIGH = 2'b01,
    DRV_RUN  = 2'b10
  } drv_e;

  typedef enum logic [2:0] {
    PH_OFF,
    PH_PARK,
    PH_RAMP,
    PH_RUN,
    PH_FAULT
  } phase_e;
endpackage

// File: rtl/pd_exit_timer.sv
module pd_exit_timer #(
  parameter int unsigned TIMEOUT_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign expired_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (run_i && !expired_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pd_exit_ramp.sv
module pd_exit_ramp #(
  parameter int unsigned N_GRP = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  output logic [N_GRP-1:0] on_o,
  output logic             full_o
);
  // thermometer: one more group released per step, lowest index first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     on_o <= '0;
    else if (clr_i)  on_o <= '0;
    else if (step_i) on_o <= (on_o << 1) | N_GRP'(1);
  end

  assign full_o = on_o[N_GRP-1];
endmodule

// File: rtl/pd_exit_drv.sv
module pd_exit_drv
  import pd_exit_seq_pkg::*;
#(
  parameter int unsigned N_GRP = 4
) (
  input  logic               off_i,
  input  logic [N_GRP-1:0]   on_i,
  output logic [2*N_GRP-1:0] mode_o
);
  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    drv_e m;
    always_comb begin
      if (off_i)        m = DRV_HIZ;
      else if (on_i[g]) m = DRV_RUN;
      else              m = DRV_HIGH;
    end
    assign mode_o[2*g +: 2] = m;
  end
endmodule

// File: rtl/pd_exit_seq.sv
module pd_exit_seq
  import pd_exit_seq_pkg::*;
#(
  parameter int unsigned N_GRP       = 4,
  parameter int unsigned TIMEOUT_CYC = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pwr_dn_i,
  input  logic               lock_i,
  output logic [2*N_GRP-1:0] mode_o,
  output logic               err_o
);
  phase_e phase_q, phase_d;
  logic tmr_clr, tmr_run, tmr_exp;
  logic ramp_clr, ramp_step, ramp_full;
  logic [N_GRP-1:0] on;

  always_comb begin
    phase_d   = phase_q;
    tmr_clr   = 1'b0;
    tmr_run   = 1'b0;
    ramp_clr  = 1'b0;
    ramp_step = 1'b0;
    if (pwr_dn_i) begin
      phase_d  = PH_OFF;
      tmr_clr  = 1'b1;
      ramp_clr = 1'b1;
    end else begin
      unique case (phase_q)
        PH_OFF: begin
          phase_d  = PH_PARK;
          tmr_clr  = 1'b1;
          ramp_clr = 1'b1;
        end
        PH_PARK: begin
          if (lock_i) begin
            ramp_step = 1'b1;
            phase_d   = PH_RAMP;
          end else if (tmr_exp) begin
            phase_d = PH_FAULT;
          end else begin
            tmr_run = 1'b1;
          end
        end
        PH_RAMP: begin
          if (ramp_full) phase_d = PH_RUN;
          else           ramp_step = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_OFF;
    else         phase_q <= phase_d;
  end

  pd_exit_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (tmr_clr),
    .run_i    (tmr_run),
    .expired_o(tmr_exp)
  );

  pd_exit_ramp #(.N_GRP(N_GRP)) i_ramp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (ramp_clr),
    .step_i(ramp_step),
    .on_o  (on),
    .full_o(ramp_full)
  );

  pd_exit_drv #(.N_GRP(N_GRP)) i_drv (
    .off_i (phase_q == PH_OFF),
    .on_i  (on),
    .mode_o(mode_o)
  );

  assign err_o = (phase_q == PH_FAULT);
endmodule

// File: rtl/pd_exit_seq_chk.sv
module pd_exit_seq_chk #(
  parameter int unsigned N_GRP       = 4,
  parameter int unsigned TIMEOUT_CYC = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               pwr_dn_i,
  input logic               lock_i,
  input logic [2*N_GRP-1:0] mode_o,
  input logic               err_o
);
  logic [N_GRP-1:0] run_v, hi_v;
  for (genvar g = 0; g < N_GRP; g++) begin : g_dec
    assign run_v[g] = (mode_o[2*g +: 2] == 2'b10);
    assign hi_v[g]  = (mode_o[2*g +: 2] == 2'b01);
  end

  // R2
  hiz_on_pd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_dn_i |=> (mode_o == '0 && !err_o));

  // R3
  park_after_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == '0 && !pwr_dn_i) |=> (hi_v == '1));

  // R4
  one_step_per_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_dn_i |=> ($countones(run_v) <= $countones($past(run_v)) + 1));

  // R6
  fault_parked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (hi_v == '1));

  // R6
  fault_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !pwr_dn_i) |=> err_o);

  // R8
  run_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_dn_i && run_v[0]) |=> run_v[0]);

  // R9
  for (genvar g = 0; g < N_GRP; g++) begin : g_code
    legal_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_o[2*g +: 2] != 2'b11);
  end

  // R9
  for (genvar g = 1; g < N_GRP; g++) begin : g_ord
    order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_v[g] |-> run_v[g-1]);
  end
endmodule

bind pd_exit_seq pd_exit_seq_chk #(.N_GRP(N_GRP), .TIMEOUT_CYC(TIMEOUT_CYC)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pwr_dn_i(pwr_dn_i),
  .lock_i  (lock_i),
  .mode_o  (mode_o),
  .err_o   (err_o)
);

// File: tb/test_pd_exit_seq.sv
module test_pd_exit_seq;
  localparam int NG = 3;
  localparam int TO = 5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic pwr_dn_i = 1'b0;
  logic lock_i = 1'b0;
  logic [2*NG-1:0] mode_o;
  logic err_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  pd_exit_seq #(.N_GRP(NG), .TIMEOUT_CYC(TO)) i_pd_exit_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwr_dn_i(pwr_dn_i),
    .lock_i(lock_i), .mode_o(mode_o), .err_o(err_o)
  );

  function automatic logic [2*NG-1:0] exp_v(int ones, bit off);
    logic [2*NG-1:0] v;
    for (int g = 0; g < NG; g++)
      v[2*g +: 2] = off ? 2'b00 : ((g < ones) ? 2'b10 : 2'b01);
    return v;
  endfunction

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic check(string req, logic [2*NG-1:0] em, logic ee);
    n_vec++;
    if (mode_o !== em || err_o !== ee) begin
      n_bad++;
      $display("FAIL %s: mode=%b err=%b expected mode=%b err=%b", req, mode_o, err_o, em, ee);
    end
  endtask

  initial begin
    // R1 reset state
    tick();
    check("R1", exp_v(0, 1), 1'b0);
    tick();
    rst_ni = 1'b1;
    tick();
    check("R3", exp_v(0, 0), 1'b0);

    // lock delay sweep across the timeout window
    for (int d = 0; d <= TO + 2; d++) begin
      pwr_dn_i = 1'b1; lock_i = 1'b0;
      tick();
      check("R2", exp_v(0, 1), 1'b0);
      pwr_dn_i = 1'b0;
      tick();
      check("R3", exp_v(0, 0), 1'b0);
      for (int t = 1; t <= d + NG + 2; t++) begin
        lock_i = (t == d + 1) ? 1'b1 : ((t > d + 1) ? !(d % 2 == 1) : 1'b0);
        tick();
        if (d < TO) begin
          if (t <= d) check("R4", exp_v(0, 0), 1'b0);
          else if (d == TO - 1) check("R7", exp_v((t - d > NG) ? NG : t - d, 0), 1'b0);
          else if (d % 2 == 1) check("R8", exp_v((t - d > NG) ? NG : t - d, 0), 1'b0);
          else check("R4", exp_v((t - d > NG) ? NG : t - d, 0), 1'b0);
        end else begin
          check("R6", exp_v(0, 0), (t >= TO) ? 1'b1 : 1'b0);
        end
      end
    end

    // power-down during every ramp state, then restart; lock held high through off (R5)
    for (int k = 0; k <= NG; k++) begin
      pwr_dn_i = 1'b1; lock_i = 1'b1;
      tick();
      check("R2", exp_v(0, 1), 1'b0);
      tick();
      check("R5", exp_v(0, 1), 1'b0);
      pwr_dn_i = 1'b0;
      tick();
      check("R5", exp_v(0, 0), 1'b0);
      for (int t = 1; t <= k + 1; t++) begin
        tick();
        check("R4", exp_v((t > NG) ? NG : t, 0), 1'b0);
      end
      pwr_dn_i = 1'b1;
      tick();
      check("R2", exp_v(0, 1), 1'b0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule